// File: doc/BRIEF.md
# Short Pulse Capture Synchronizer

This block carries a single asynchronous event into a clocked destination domain, including events whose pulse is narrower than one destination clock period. A plain chain of flip-flops on the destination clock would sample such a pulse only by chance. Here the rising edge of the event input clocks a capture flip-flop whose data input is a constant 1. The captured level therefore stays put until the destination domain has seen it.

A resynchronizing chain of `SYNC_STAGES` flip-flops on the destination clock carries the captured level to the output. When the output goes high, it asynchronously clears the capture flip-flop, so the block rearms itself without any handshake back to the source. The capture flip-flop is also cleared by the active-high global reset. Rising edges that arrive while a capture is still pending merge into that one event.

The chain depth is a parameter checked at elaboration, and a generate loop builds the chain. Downstream logic sees a clean level pulse of known width for each event.

Top module: `pulse_catch_sync`

## Requirements
- R1: While `rst` is high, and after it is released until the first event, `evt_sync` is 0.
- R2: A rising edge on `evt_async` is captured whatever its phase relative to `clk`, even when the high time is much shorter than a `clk` period.
- R3: After a capture, `evt_sync` stays low at the first rising `clk` edge and goes high at the `SYNC_STAGES`-th rising `clk` edge (the second with the default of 2).
- R4: A high `evt_sync` clears the capture flip-flop, so `evt_sync` returns low after each event instead of staying high.
- R5: Each isolated event makes `evt_sync` high for exactly `SYNC_STAGES` consecutive `clk` cycles, one assertion only.
- R6: Asserting `rst` clears the capture flip-flop and every chain stage asynchronously, so a pending capture produces no output.
- R7: Further rising edges on `evt_async` while a capture is pending merge with it and produce no second assertion.
- R8: An `evt_async` level held high over many `clk` periods produces a single assertion, because capture is edge triggered.
- R9: A rising edge on `evt_async` while `rst` is high is ignored.
- R10: `SYNC_STAGES` below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination clock |
| rst | input | 1 | Asynchronous active-high reset for all flip-flops |
| evt_async | input | 1 | Asynchronous event input; its rising edge is captured |
| evt_sync | output | 1 | Synchronized event level, high for `SYNC_STAGES` cycles per event |

## Verification
The assertions assume that isolated events are spaced far enough apart that each has left the chain before the next rising edge arrives. They also assume that no input edge lands exactly on a `clk` edge, since such an edge would make the model's capture timing depend on the order of processes. The stimulus sweeps pulse start offsets from 1 to 6 ns after a clock edge and widths of 1 ns and up. It leaves several idle cycles between events, so the windows stay separate. Only the merge and wide-pulse cases add extra edges, and they place those edges while the capture is known to be pending or the level is already held.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   localparam int unsigned PCS_MIN_STAGES = 2;

   function automatic int unsigned pcs_run_width(input int unsigned stages);
      return $clog2(stages + 2);
   endfunction
endpackage

// File: rtl/pcs_edge_capture.sv
module pcs_edge_capture (
   input  logic evt_async,
   input  logic clr,
   output logic held
);
   // Data input tied high: any rising edge sets the level.
   always_ff @(posedge evt_async or posedge clr) begin
      if (clr) held <= 1'b0;
      else     held <= 1'b1;
   end
endmodule

// File: rtl/pcs_resync_chain.sv
module pcs_resync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              din,
   output logic [STAGES-1:0] taps
);
   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk or posedge rst) begin
               if (rst) taps[gi] <= 1'b0;
               else     taps[gi] <= din;
            end
         end else begin : g_tail
            always_ff @(posedge clk or posedge rst) begin
               if (rst) taps[gi] <= 1'b0;
               else     taps[gi] <= taps[gi-1];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pulse_catch_sync.sv
module pulse_catch_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic evt_async,
   output logic evt_sync
);
   import pcs_pkg::*;

   localparam int unsigned RUN_W = pcs_run_width(SYNC_STAGES);

   // R10: elaboration check on the chain depth
   generate
      if (SYNC_STAGES < PCS_MIN_STAGES) begin : g_bad_depth
         $error("pulse_catch_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                   held;
   logic                   cap_clr;
   logic [SYNC_STAGES-1:0] taps;

   assign cap_clr = rst | evt_sync;

   pcs_edge_capture u_cap (
      .evt_async (evt_async),
      .clr       (cap_clr),
      .held      (held)
   );

   pcs_resync_chain #(.STAGES(SYNC_STAGES)) u_chain (
      .clk  (clk),
      .rst  (rst),
      .din  (held),
      .taps (taps)
   );

   assign evt_sync = taps[SYNC_STAGES-1];

   // Assertion-only run counter of consecutive high output cycles
   logic [RUN_W-1:0] hi_run;
   always_ff @(posedge clk or posedge rst) begin
      if (rst)           hi_run <= '0;
      else if (evt_sync) hi_run <= hi_run + 1'b1;
      else               hi_run <= '0;
   end

   p_capture_cleared_r4: assert property (@(posedge clk) disable iff (rst)
      evt_sync |-> !held);

   p_first_tap_from_capture_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(taps[0]) |-> $past(held));

   p_hold_after_rise_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(evt_sync) |=> evt_sync);

   p_bounded_width_r5: assert property (@(posedge clk) disable iff (rst)
      hi_run <= RUN_W'(SYNC_STAGES));

   p_reset_clears_r6: assert property (@(posedge clk)
      $past(rst) |-> (!evt_sync && !held));
endmodule

// File: tb/pulse_catch_sync_tb_top.sv
`timescale 1ns/1ps
module pulse_catch_sync_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic evt_async = 1'b0;
   logic evt_sync;

   int n_cmp = 0;
   int n_bad = 0;
   int rises = 0;

   pulse_catch_sync #(.SYNC_STAGES(2)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .evt_async (evt_async),
      .evt_sync  (evt_sync)
   );

   always #4 clk = ~clk;

   always @(posedge evt_sync) rises++;

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_cnt(input int act, input int exp, input string tag);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
   endtask

   // Isolated short pulse: starts off ns after an edge, lasts w ns, ends before next edge
   task automatic short_event(input int off, input int w);
      int r0;
      @(posedge clk);
      r0 = rises;
      #(off) evt_async = 1'b1;
      #(w)   evt_async = 1'b0;
      @(posedge clk); #1 chk(evt_sync, 1'b0, "R3 low after first edge");
      @(posedge clk); #1 chk(evt_sync, 1'b1, "R2 R3 high at second edge");
      @(posedge clk); #1 chk(evt_sync, 1'b1, "R5 second high cycle");
      @(posedge clk); #1 chk(evt_sync, 1'b0, "R4 R5 back low");
      idle(2);
      chk_cnt(rises - r0, 1, "R5 one assertion per event");
   endtask

   initial begin : watchdog
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int r0;
      // R1 / R9: edge during reset ignored
      #3 chk(evt_sync, 1'b0, "R1 out low in reset");
      #2 evt_async = 1'b1;
      #1 evt_async = 1'b0;
      idle(2);
      #1 chk(evt_sync, 1'b0, "R1 out low in reset");
      rst = 1'b0;
      r0 = rises;
      idle(4);
      #1 chk(evt_sync, 1'b0, "R9 edge in reset ignored");
      chk_cnt(rises - r0, 0, "R9 no assertion");

      // R2 R3 R4 R5: sweep offset and width
      for (int off = 1; off <= 6; off++) begin
         for (int w = 1; w <= 7 - off; w++) begin
            short_event(off, w);
         end
      end

      // R7: merged edges while capture pending
      @(posedge clk);
      r0 = rises;
      #1 evt_async = 1'b1;
      #1 evt_async = 1'b0;
      #2 evt_async = 1'b1;
      #1 evt_async = 1'b0;
      @(posedge clk);
      #1 evt_async = 1'b1;
      #1 evt_async = 1'b0;
      @(posedge clk); #1 chk(evt_sync, 1'b1, "R7 merged event high");
      idle(6);
      #1 chk(evt_sync, 1'b0, "R7 merged event low");
      chk_cnt(rises - r0, 1, "R7 single assertion for merged edges");

      // R8: wide level
      @(posedge clk);
      r0 = rises;
      #2 evt_async = 1'b1;
      #60 evt_async = 1'b0;
      idle(6);
      #1 chk(evt_sync, 1'b0, "R8 low after wide pulse");
      chk_cnt(rises - r0, 1, "R8 single assertion for wide pulse");

      // R6: reset while capture pending
      @(posedge clk);
      r0 = rises;
      #2 evt_async = 1'b1;
      #1 evt_async = 1'b0;
      #1 rst = 1'b1;
      #1 chk(evt_sync, 1'b0, "R6 out low in reset");
      #2 rst = 1'b0;
      idle(5);
      #1 chk(evt_sync, 1'b0, "R6 pending capture dropped");
      chk_cnt(rises - r0, 0, "R6 no assertion after reset");

      // R6: reset while output high
      @(posedge clk);
      #2 evt_async = 1'b1;
      #1 evt_async = 1'b0;
      idle(2);
      #1 chk(evt_sync, 1'b1, "R6 high before reset");
      rst = 1'b1;
      #1 chk(evt_sync, 1'b0, "R6 async clear of output");
      #2 rst = 1'b0;

      // Recovery after reset
      short_event(3, 2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule